// File: doc/BRIEF.md
# External DMA Request Sequencer

This block turns a level-sensitive, active-low request pin into block transfers on a simple bus. Software arms the channel with a one-cycle write strobe. The strobe also captures the block length, the number of blocks, and the base addresses for source and destination. While the channel is idle and armed, the block samples the pin on every rising clock edge. A low level is held as a pending request. The pin does not need to stay low.

An activation step clears the pending request and asks for the bus. Once the bus is granted, the block performs one whole block. A block is a series of read/write pairs: each read from the source is held in a buffer register and then written to the destination. Both addresses step up by one per access. A single dead cycle follows the last write of the block, and only after it does the block watch the pin again. When the last programmed block is done, the channel disarms itself and pulses a transfer-end flag.

The bus side uses a held-strobe handshake, which serves as its back-pressure. `bus_rd` or `bus_wr` stays high, with a stable address, until the bus answers with a one-cycle `bus_done`. The bus can therefore stall any access for as long as it needs. `bus_req` asks for ownership and waits for `bus_gnt`.

Top module: `xdma_req_seq`

## Requirements
- R1: A cycle with `en_wr`=1 and `en_wdata`=1 arms the channel (`chan_en`=1 from the next cycle) and captures length, count and base addresses. This happens only while the sequencer is idle and both `blk_len` and `xfer_cnt` are nonzero. Otherwise the write leaves `chan_en` unchanged.
- R2: The request pin is ignored on the clock edge that performs the arming write. Sampling starts at the first rising edge after that write.
- R3: A low `req_n` seen on an edge where acceptance is open (armed, idle, nothing pending) becomes a pending request. A single low cycle is enough to cause one block.
- R4: `bus_rd` for the first read of a block rises no earlier than the third rising edge after the edge that latched the request. With an immediate grant, it rises exactly on that third edge.
- R5: A block of length N is N pairs in this order: a read at address src, then a write at address dst carrying the data just read. Each access moves its own address up by one. Addresses continue from block to block.
- R6: `bus_rd` and `bus_wr` are never high together. Each stays high with an unchanged address until `bus_done`. `bus_req` stays high from the request phase through the block's last write.
- R7: Exactly one dead cycle with `bus_req`=0 follows a block's last write. Pin samples taken from the latching edge until that dead cycle is over cause no extra block.
- R8: After `xfer_cnt` blocks, `chan_en` falls and `xfer_end` pulses high for exactly one cycle. After that, a low pin starts no bus activity.
- R9: A cycle with `en_wr`=1 and `en_wdata`=0 disarms the channel and drops any pending request. A block already on the bus still finishes.
- R10: A synchronous reset `rst` clears the enable, the pending request and all counters, and returns the sequencer to idle with all bus strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 1 | Enable value written (1 arm, 0 disarm) |
| blk_len | input | LEN_W | Read/write pairs per block, captured on arming |
| xfer_cnt | input | CNT_W | Number of blocks, captured on arming |
| src_base | input | AW | First source address |
| dst_base | input | AW | First destination address |
| req_n | input | 1 | External transfer request, active low, level sampled |
| chan_en | output | 1 | Channel armed |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_rd | output | 1 | Read strobe, held until `bus_done` |
| bus_wr | output | 1 | Write strobe, held until `bus_done` |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data (buffered read data) |
| bus_rdata | input | DW | Read data, taken with `bus_done` |
| bus_done | input | 1 | Access complete, one cycle |
| xfer_end | output | 1 | One-cycle pulse after the final block |

## Verification
The bench builds the block with 3-bit length and count fields and 16-bit addresses and data. At that size, every length from 1 to 3 and every count from 1 to 3 can be swept. Each pair is crossed with grant latencies of 0 and 1 and with completion delays of 0 to 2 cycles. This covers single-pair blocks, single-block transfers and back-to-back blocks under a held-low pin. Directed runs place one-cycle pin pulses on the arming edge, during a block and after completion. They also cover refused arming writes, disarming between blocks and reset in the middle of a read. This is enough to measure the exact latch-to-read latency and the dead-cycle spacing.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_ARM  = 3'd1,
    SQ_REQ  = 3'd2,
    SQ_RD   = 3'd3,
    SQ_WR   = 3'd4,
    SQ_DEAD = 3'd5
  } seq_state_t;
endpackage

// File: rtl/xdma_req_gate.sv
// Channel enable register and pending-request latch.
module xdma_req_gate (
  input  logic clk,
  input  logic rst,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic cfg_ok,
  input  logic idle,
  input  logic act_start,
  input  logic fin,
  input  logic req_n,
  output logic chan_en,
  output logic pend,
  output logic load
);
  logic accept_open;

  assign load        = en_wr && en_wdata && cfg_ok && idle;
  assign accept_open = chan_en && idle && !pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en <= 1'b0;
    end else if (en_wr && !en_wdata) begin
      chan_en <= 1'b0;
    end else if (load) begin
      chan_en <= 1'b1;
    end else if (fin) begin
      chan_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (en_wr && !en_wdata) begin
      pend <= 1'b0;
    end else if (act_start) begin
      pend <= 1'b0;
    end else if (accept_open && !req_n) begin
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/xdma_seq_ctrl.sv
// Block sequencer: activation, bus request, read/write pairs, dead cycle.
module xdma_seq_ctrl
  import xdma_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             pend,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic             bus_gnt,
  input  logic             bus_done,
  output logic             idle,
  output logic             act_start,
  output logic             fin,
  output logic             bus_req,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic             rd_acc,
  output logic             wr_acc,
  output logic             xfer_end
);
  localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  seq_state_t       state;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] beat;
  logic [CNT_W-1:0] blk_left;
  logic             last_beat;

  assign idle      = (state == SQ_IDLE);
  assign act_start = (state == SQ_ARM);
  assign bus_rd    = (state == SQ_RD);
  assign bus_wr    = (state == SQ_WR);
  assign bus_req   = (state == SQ_REQ) || bus_rd || bus_wr;
  assign rd_acc    = bus_rd && bus_done;
  assign wr_acc    = bus_wr && bus_done;
  assign last_beat = (beat == len_q - ONE_L);
  assign fin       = (state == SQ_DEAD) && (blk_left == ONE_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      len_q    <= '0;
      beat     <= '0;
      blk_left <= '0;
      xfer_end <= 1'b0;
    end else begin
      xfer_end <= 1'b0;
      if (load) begin
        len_q    <= blk_len;
        blk_left <= xfer_cnt;
      end
      case (state)
        SQ_IDLE: if (pend) state <= SQ_ARM;
        SQ_ARM:  state <= SQ_REQ;
        SQ_REQ: begin
          if (bus_gnt) begin
            beat  <= '0;
            state <= SQ_RD;
          end
        end
        SQ_RD: if (bus_done) state <= SQ_WR;
        SQ_WR: begin
          if (bus_done) begin
            if (last_beat) begin
              state <= SQ_DEAD;
            end else begin
              beat  <= beat + ONE_L;
              state <= SQ_RD;
            end
          end
        end
        SQ_DEAD: begin
          blk_left <= blk_left - ONE_C;
          xfer_end <= fin;
          state    <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xdma_datapath.sv
// Address counters and read-data buffer.
module xdma_datapath #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic          rd_acc,
  input  logic          wr_acc,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);
  localparam logic [AW-1:0] STEP = AW'(1);

  logic [AW-1:0] src_a;
  logic [AW-1:0] dst_a;
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_a  <= '0;
      dst_a  <= '0;
      hold_q <= '0;
    end else begin
      if (load) begin
        src_a <= src_base;
        dst_a <= dst_base;
      end
      if (rd_acc) begin
        hold_q <= bus_rdata;
        src_a  <= src_a + STEP;
      end
      if (wr_acc) begin
        dst_a <= dst_a + STEP;
      end
    end
  end

  assign bus_addr  = bus_wr ? dst_a : src_a;
  assign bus_wdata = hold_q;
endmodule

// File: rtl/xdma_req_seq.sv
module xdma_req_seq #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int LEN_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic [AW-1:0]    src_base,
  input  logic [AW-1:0]    dst_base,
  input  logic             req_n,
  output logic             chan_en,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_done,
  output logic             xfer_end
);
  logic cfg_ok, idle, act_start, fin, pend, load, rd_acc, wr_acc;

  assign cfg_ok = (blk_len != '0) && (xfer_cnt != '0);

  xdma_req_gate u_gate (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
    .cfg_ok(cfg_ok), .idle(idle), .act_start(act_start), .fin(fin),
    .req_n(req_n), .chan_en(chan_en), .pend(pend), .load(load)
  );

  xdma_seq_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .load(load), .pend(pend),
    .blk_len(blk_len), .xfer_cnt(xfer_cnt),
    .bus_gnt(bus_gnt), .bus_done(bus_done),
    .idle(idle), .act_start(act_start), .fin(fin),
    .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .rd_acc(rd_acc), .wr_acc(wr_acc), .xfer_end(xfer_end)
  );

  xdma_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .load(load),
    .src_base(src_base), .dst_base(dst_base),
    .rd_acc(rd_acc), .wr_acc(wr_acc), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );
endmodule

// File: rtl/xdma_req_seq_chk.sv
module xdma_req_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          chan_en,
  input logic          pend,
  input logic          idle,
  input logic          bus_req,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_done,
  input logic [AW-1:0] bus_addr,
  input logic          xfer_end
);
  logic       pend_q;
  logic [2:0] since_latch;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      since_latch <= 3'd0;
    end else begin
      pend_q <= pend;
      if (pend && !pend_q) since_latch <= 3'd1;
      else if (since_latch != 3'd7) since_latch <= since_latch + 3'd1;
    end
  end

  // R2
  latch_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(chan_en));
  // R7
  latch_only_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(idle));
  // R4
  read_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd) |-> since_latch >= 3'd3);
  // R6
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_done) |=> (bus_rd && $stable(bus_addr)));
  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_done) |=> (bus_wr && $stable(bus_addr)));
  // R8
  end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_end |=> !xfer_end);
  // R8
  end_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_end |-> !chan_en);
  // R10
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!chan_en && !pend && !bus_req && !xfer_end));
endmodule

bind xdma_req_seq xdma_req_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .chan_en(chan_en), .pend(pend), .idle(idle),
  .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_done(bus_done),
  .bus_addr(bus_addr), .xfer_end(xfer_end)
);

// File: tb/xdma_req_seq_test.sv
module xdma_req_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 16, LEN_W = 3, CNT_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_wr = 1'b0, en_wdata = 1'b0;
  logic [LEN_W-1:0] blk_len = '0;
  logic [CNT_W-1:0] xfer_cnt = '0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic req_n = 1'b1;
  logic chan_en, bus_req, bus_rd, bus_wr, xfer_end;
  logic bus_gnt = 1'b0, bus_done = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int n_run = 0, n_fail = 0;
  int G = 0, D = 0, gcnt = 0, dcnt = 0;
  int wr_n = 0, rd_n = 0, end_n = 0;
  int sweep = 0, cur_bl = 1, cur_xc = 1, gap = 0, gap_on = 0;
  logic [AW-1:0] exp_src, exp_dst;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_rdata = bus_addr ^ 16'h5A3C;

  xdma_req_seq #(.AW(AW), .DW(DW), .LEN_W(LEN_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
    .blk_len(blk_len), .xfer_cnt(xfer_cnt), .src_base(src_base),
    .dst_base(dst_base), .req_n(req_n), .chan_en(chan_en),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_done(bus_done), .xfer_end(xfer_end)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bus model and monitor, all at the falling edge.
  always @(negedge clk) begin
    bit was_done;
    was_done = bus_done;
    bus_done = 1'b0;
    if (!bus_req) begin
      bus_gnt = 1'b0; gcnt = 0;
    end else if (gcnt >= G) bus_gnt = 1'b1;
    else gcnt++;
    if (xfer_end) end_n++;
    if (gap_on != 0) begin
      gap++;
      if (gap == 1) chk(!bus_req, "R7", "dead cycle bus_req", int'(bus_req), 0);
      if (bus_rd) begin
        if (G == 0) chk(gap == 6, "R7", "block spacing", gap, 6);
        else chk(gap >= 6, "R7", "block spacing min", gap, 6);
        gap_on = 0;
      end
    end
    if ((bus_rd || bus_wr) && !was_done) begin
      if (dcnt >= D) begin
        bus_done = 1'b1; dcnt = 0;
        if (bus_rd) begin
          if (sweep != 0) chk(bus_addr == exp_src, "R5", "read addr", int'(bus_addr), int'(exp_src));
          exp_src = exp_src + 1'b1;
          rd_n++;
        end else begin
          if (sweep != 0) begin
            chk(bus_addr == exp_dst, "R5", "write addr", int'(bus_addr), int'(exp_dst));
            chk(bus_wdata == ((exp_src - 1'b1) ^ 16'h5A3C), "R5", "write data",
                int'(bus_wdata), int'((exp_src - 1'b1) ^ 16'h5A3C));
          end
          exp_dst = exp_dst + 1'b1;
          wr_n++;
          if (sweep != 0 && (wr_n % cur_bl) == 0 && wr_n < cur_bl * cur_xc) begin
            gap_on = 1; gap = 0;
          end
        end
      end else dcnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input int bl, input int xc, input logic [AW-1:0] s, input logic [AW-1:0] d);
    blk_len = LEN_W'(bl); xfer_cnt = CNT_W'(xc); src_base = s; dst_base = d;
    exp_src = s; exp_dst = d;
    en_wr = 1'b1; en_wdata = 1'b1;
    cyc(1);
    en_wr = 1'b0;
  endtask

  task automatic pulse_req();
    req_n = 1'b0; cyc(1); req_n = 1'b1;
  endtask

  task automatic quiet(input int n, input string req, input string what);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (bus_req) seen++;
    end
    chk(seen == 0, req, what, seen, 0);
  endtask

  task automatic wait_end(input int lim);
    for (int i = 0; i < lim; i++) begin
      cyc(1);
      if (xfer_end) break;
    end
    cyc(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int k;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R10 reset state
    chk(!chan_en && !bus_req && !bus_rd && !bus_wr && !xfer_end, "R10", "reset outputs",
        int'({chan_en, bus_req, bus_rd, bus_wr, xfer_end}), 0);

    // R1 refused arming writes
    arm(0, 2, 16'h10, 16'h20); cyc(1);
    chk(!chan_en, "R1", "zero length refused", int'(chan_en), 0);
    arm(2, 0, 16'h10, 16'h20); cyc(1);
    chk(!chan_en, "R1", "zero count refused", int'(chan_en), 0);

    // R2 pin low only on the arming edge is ignored
    blk_len = 3'd2; xfer_cnt = 3'd2; src_base = 16'h0040; dst_base = 16'h0400;
    exp_src = src_base; exp_dst = dst_base;
    en_wr = 1'b1; en_wdata = 1'b1; req_n = 1'b0;
    cyc(1);
    en_wr = 1'b0; req_n = 1'b1;
    chk(chan_en, "R1", "armed", int'(chan_en), 1);
    quiet(15, "R2", "pin on arming edge ignored");

    // R3 single-cycle pulse latched; R4 exact latency with immediate grant
    wr_n = 0; rd_n = 0;
    req_n = 1'b0;
    k = 0;
    for (int i = 0; i < 30; i++) begin
      cyc(1);
      req_n = 1'b1;
      k++;
      if (bus_rd) break;
    end
    chk(k == 4, "R4", "latch to read", k, 4);
    // R7 pulse during the block must not add a block
    cyc(1); pulse_req();
    cyc(40);
    chk(wr_n == 2, "R3", "one block from one pulse", wr_n, 2);
    chk(wr_n == 2 && rd_n == 2, "R7", "busy pulse ignored", wr_n, 2);
    pulse_req();
    end_n = 0;
    wait_end(200);
    chk(wr_n == 4, "R8", "second block", wr_n, 4);
    chk(end_n == 1, "R8", "end pulse count", end_n, 1);
    chk(!chan_en, "R8", "disarmed after end", int'(chan_en), 0);
    req_n = 1'b0;
    quiet(20, "R8", "no activity after end");
    req_n = 1'b1;

    // R9 disarm between blocks
    arm(1, 3, 16'h0100, 16'h0200);
    wr_n = 0;
    pulse_req();
    cyc(30);
    chk(wr_n == 1, "R9", "first block", wr_n, 1);
    en_wr = 1'b1; en_wdata = 1'b0; cyc(1); en_wr = 1'b0;
    chk(!chan_en, "R9", "disarmed", int'(chan_en), 0);
    pulse_req();
    quiet(20, "R9", "no block after disarm");
    // R1 re-arm reloads base addresses
    arm(1, 1, 16'h0300, 16'h0500);
    pulse_req();
    cyc(30);
    chk(exp_dst == 16'h0501, "R1", "reloaded dst", int'(exp_dst), 16'h0501);

    // R10 reset in the middle of a read
    arm(3, 2, 16'h0600, 16'h0700);
    D = 3;
    req_n = 1'b0;
    for (int i = 0; i < 30; i++) begin
      cyc(1);
      if (bus_rd) break;
    end
    rst = 1'b1; cyc(1); rst = 1'b0;
    chk(!chan_en && !bus_req && !bus_rd && !bus_wr, "R10", "mid-block reset",
        int'({chan_en, bus_req, bus_rd, bus_wr}), 0);
    quiet(20, "R10", "pending and enable cleared");
    req_n = 1'b1;
    D = 0;
    cyc(5);

    // Sweep: R5 R6 R7 R8 over length, count, grant and done latency
    sweep = 1;
    for (int bl = 1; bl <= 3; bl++)
      for (int xc = 1; xc <= 3; xc++)
        for (int g = 0; g <= 1; g++)
          for (int d = 0; d <= 2; d++) begin
            G = g; D = d; cur_bl = bl; cur_xc = xc;
            wr_n = 0; end_n = 0; gap_on = 0;
            arm(bl, xc, AW'(16'h1000 + bl * 64 + xc * 8), AW'(16'h9000 + g * 256 + d * 16));
            req_n = 1'b0;
            wait_end(400);
            req_n = 1'b1;
            chk(wr_n == bl * xc, "R8", "writes per transfer", wr_n, bl * xc);
            chk(end_n == 1, "R8", "end pulses", end_n, 1);
            chk(!chan_en, "R8", "disarmed", int'(chan_en), 0);
            cyc(2);
          end
    sweep = 0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule